// File: doc/BRIEF.md
# Dual-Channel Host Register Decoder

This block sits between an 8-bit host bus and the register files of two identical serial channels. The host drives an active-low chip select, a channel select line, a 3-bit register address, an 8-bit write data bus and separate active-low read and write strobes. The decoder steers every write to one channel and returns read data from the channel named by the channel select line.

Write strobes come from a bus that is not tied to the system clock. The decoder passes the write strobe through a two-flop synchronizer. It commits a write when it sees the strobe return high. It samples the address, data and selects along the same delay path, so those values line up with the strobe.

Each channel has an alternate-function register. When bit 0 of that register is set in either channel, the decoder enters broadcast mode. In broadcast mode a single write cycle updates the addressed register in both channels, which is useful during initialisation. Reads are never broadcast.

Top module: `dual_chan_regdec`

## Requirements
- R1: A synchronous active-high reset clears all eight registers of both channels to 0x00, so broadcast mode is off after reset, and no register is written in the first cycle after reset.
- R2: While cs_n is high, a write cycle changes no register, and a read leaves rdata at 0x00 with rdata_oe low.
- R3: With broadcast off, chan_sel = 1 selects channel A and chan_sel = 0 selects channel B, for both writes and reads. A write updates exactly one channel.
- R4: addr selects one of eight registers in a channel. A write changes only the register at that address.
- R5: A write commits on the rising edge of wr_n. The new value becomes visible on the third rising clock edge after wr_n goes high, and not before. The committed address, data and selects are the values held while wr_n was low.
- R6: Address 7 in each channel is the alternate-function register. When bit 0 is set in either channel, a write with cs_n low updates the addressed register in both channels, whatever chan_sel is.
- R7: While broadcast mode is on, a read returns the register of the channel named by chan_sel.
- R8: While cs_n and rd_n are both low, rdata shows the addressed register of the selected channel and rdata_oe is high. At all other times rdata is 0x00 and rdata_oe is low.
- R9: A write of a value with bit 0 clear to address 7 while broadcast is on clears both alternate-function registers. After that, writes go to a single channel again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| chan_sel | input | 1 | Channel select: 1 selects channel A, 0 selects channel B |
| addr | input | 3 | Register address within a channel |
| wr_n | input | 1 | Write strobe, active low; commits on its rising edge |
| rd_n | input | 1 | Read strobe, active low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0x00 when no read is active |
| rdata_oe | output | 1 | High while read data is being driven |

## Verification
The assertions assume that wr_n is high during reset and that each write strobe stays low, and then high, for longer than the synchronizer depth, so every write produces exactly one commit pulse. They also assume that cs_n, chan_sel, addr and wdata stay stable for the whole time wr_n is low. The bench holds every write strobe low for three clocks and keeps the bus fields steady until after the commit. It changes inputs only at falling clock edges, and it raises rd_n low just after each write so that a reference model, updated on the exact commit edge, catches a commit that comes too early or too late.

// File: rtl/regdec_pkg.sv
package regdec_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int NUM_CH    = 2;
    localparam int REG_COUNT = 1 << ADDR_W;
    localparam int BCAST_BIT = 0;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Channel index: A is entry 0, B is entry 1
    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    // One host access as seen on the bus pins
    typedef struct packed {
        logic  sel;
        chan_e chan;
        addr_t addr;
        data_t data;
    } bus_req_t;

    function automatic chan_e decode_chan(input logic chan_sel);
        return chan_sel ? CH_A : CH_B;
    endfunction

endpackage

// File: rtl/regdec_wr_sync.sv
module regdec_wr_sync
    import regdec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_n,
    input  bus_req_t req_in,
    output logic     commit,
    output bus_req_t req_out
);

    localparam int LAST = SYNC_STAGES - 1;

    // Entries 0..LAST are the synchronizer; entry SYNC_STAGES is the previous value
    logic [SYNC_STAGES:0] wr_pipe;
    bus_req_t             req_pipe [SYNC_STAGES];
    bus_req_t             held_q;
    logic                 wr_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pipe <= '1;
        end else begin
            wr_pipe <= {wr_pipe[SYNC_STAGES-1:0], wr_n};
        end
    end

    // Bus fields travel with the same latency as the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) begin
                req_pipe[i] <= '0;
            end
        end else begin
            req_pipe[0] <= req_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                req_pipe[i] <= req_pipe[i-1];
            end
        end
    end

    assign wr_sync = wr_pipe[LAST];

    // Keep the last fields seen while the strobe was low
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (!wr_sync) begin
            held_q <= req_pipe[LAST];
        end
    end

    assign commit  = wr_sync & ~wr_pipe[SYNC_STAGES];
    assign req_out = held_q;

endmodule

// File: rtl/regdec_steer.sv
module regdec_steer
    import regdec_pkg::*;
(
    input  logic              commit,
    input  bus_req_t          req,
    input  logic [NUM_CH-1:0] bcast_bits,
    output logic [NUM_CH-1:0] we,
    output logic              broadcast
);

    assign broadcast = |bcast_bits;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        assign we[c] = commit & req.sel & (broadcast | (int'(req.chan) == c));
    end

endmodule

// File: rtl/regdec_chan_regs.sv
module regdec_chan_regs
    import regdec_pkg::*;
#(
    parameter int AFR_ADDR = REG_COUNT - 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t waddr,
    input  data_t wdata,
    input  addr_t raddr,
    output data_t rdata,
    output logic  bcast_bit
);

    data_t regs [REG_COUNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata     = regs[raddr];
    assign bcast_bit = regs[AFR_ADDR][BCAST_BIT];

endmodule

// File: rtl/dual_chan_regdec.sv
module dual_chan_regdec
    import regdec_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int AFR_ADDR    = REG_COUNT - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              chan_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    bus_req_t          pin_req;
    bus_req_t          wr_req;
    logic              wr_commit;
    logic              bcast_on;
    logic [NUM_CH-1:0] ch_we;
    logic [NUM_CH-1:0] ch_bcast;
    data_t             ch_rdata [NUM_CH];
    logic              rd_active;
    chan_e             rd_chan;

    assign pin_req.sel  = ~cs_n;
    assign pin_req.chan = decode_chan(chan_sel);
    assign pin_req.addr = addr;
    assign pin_req.data = wdata;

    regdec_wr_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_wr_sync (
        .clk    (clk),
        .rst    (rst),
        .wr_n   (wr_n),
        .req_in (pin_req),
        .commit (wr_commit),
        .req_out(wr_req)
    );

    regdec_steer u_steer (
        .commit    (wr_commit),
        .req       (wr_req),
        .bcast_bits(ch_bcast),
        .we        (ch_we),
        .broadcast (bcast_on)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        regdec_chan_regs #(
            .AFR_ADDR(AFR_ADDR)
        ) u_regs (
            .clk      (clk),
            .rst      (rst),
            .we       (ch_we[c]),
            .waddr    (wr_req.addr),
            .wdata    (wr_req.data),
            .raddr    (addr),
            .rdata    (ch_rdata[c]),
            .bcast_bit(ch_bcast[c])
        );
    end

    // Reads follow the live pins and are never broadcast
    assign rd_active = ~cs_n & ~rd_n;
    assign rd_chan   = decode_chan(chan_sel);
    assign rdata     = rd_active ? ch_rdata[int'(rd_chan)] : '0;
    assign rdata_oe  = rd_active;

endmodule

// File: rtl/regdec_checker.sv
module regdec_checker
    import regdec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rd_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input logic [NUM_CH-1:0] ch_we,
    input logic              commit,
    input logic              broadcast
);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ch_we == '0);

    p_single_chan_r3: assert property (@(posedge clk) disable iff (rst)
        !broadcast |-> $onehot0(ch_we));

    p_we_needs_commit_r5: assert property (@(posedge clk) disable iff (rst)
        (|ch_we) |-> commit);

    p_commit_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    p_bcast_both_r6: assert property (@(posedge clk) disable iff (rst)
        ((|ch_we) && broadcast) |-> (ch_we == '1));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (rdata == '0 && !rdata_oe));

    p_read_drive_r8: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n) |-> rdata_oe);

endmodule

bind dual_chan_regdec regdec_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .ch_we    (ch_we),
    .commit   (wr_commit),
    .broadcast(bcast_on)
);

// File: tb/dual_chan_regdec_tb_top.sv
`timescale 1ns/1ps
module dual_chan_regdec_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       chan_sel = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model: index 0 = channel A, 1 = channel B
    logic [7:0] mreg [0:1][0:7];

    always #2 clk = ~clk;

    dual_chan_regdec dut_i (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .chan_sel(chan_sel),
        .addr    (addr),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .wdata   (wdata),
        .rdata   (rdata),
        .rdata_oe(rdata_oe)
    );

    function automatic int ch_idx(input logic cs);
        return cs ? 0 : 1;
    endfunction

    task automatic model_clear();
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 8; a++)
                mreg[c][a] = 8'h00;
    endtask

    // Per-clock comparison against the model (R8 read path, R5 commit timing)
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            logic [7:0] exp_d;
            logic       exp_oe;
            exp_oe = !cs_n && !rd_n;
            exp_d  = exp_oe ? mreg[ch_idx(chan_sel)][addr] : 8'h00;
            checks++;
            if (rdata !== exp_d || rdata_oe !== exp_oe) begin
                errors++;
                $display("FAIL R8/R5 cycle compare: rdata=%h oe=%b expected %h oe=%b",
                         rdata, rdata_oe, exp_d, exp_oe);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        model_clear();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic host_write(input logic cs, input logic csel, input logic [2:0] a,
                              input logic [7:0] d);
        logic bc;
        @(negedge clk);
        cs_n = ~cs; chan_sel = csel; addr = a; wdata = d; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        rd_n = 1'b0;  // watch the old value until the commit edge
        repeat (3) @(posedge clk);
        if (cs) begin
            bc = mreg[0][7][0] | mreg[1][7][0];
            if (bc) begin
                mreg[0][a] = d;
                mreg[1][a] = d;
            end else begin
                mreg[ch_idx(csel)][a] = d;
            end
        end
        repeat (2) @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic rd_check(input logic csel, input logic [2:0] a,
                            input logic [7:0] exp_v, input string tag);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; chan_sel = csel; addr = a;
        #1;
        checks++;
        if (rdata !== exp_v || rdata_oe !== 1'b1) begin
            errors++;
            $display("FAIL %s: ch%s reg%0d rdata=%h oe=%b expected %h oe=1",
                     tag, csel ? "A" : "B", a, rdata, rdata_oe, exp_v);
        end
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; chan_sel = 1'b1; addr = 3'd3;
        #1;
        checks++;
        if (rdata !== 8'h00 || rdata_oe !== 1'b0) begin
            errors++;
            $display("FAIL %s: rdata=%h oe=%b expected 00 oe=0", tag, rdata, rdata_oe);
        end
        @(negedge clk);
        rd_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        model_clear();
        do_reset();

        // R1: everything reads zero after reset
        for (int a = 0; a < 8; a++) begin
            rd_check(1'b1, 3'(a), 8'h00, "R1 reset A");
            rd_check(1'b0, 3'(a), 8'h00, "R1 reset B");
        end

        // R3: channel steering, R4: neighbours untouched
        host_write(1'b1, 1'b1, 3'd3, 8'h5A);
        host_write(1'b1, 1'b0, 3'd3, 8'hA5);
        rd_check(1'b1, 3'd3, 8'h5A, "R3 chan A");
        rd_check(1'b0, 3'd3, 8'hA5, "R3 chan B");
        rd_check(1'b1, 3'd2, 8'h00, "R4 neighbour untouched");

        // R2: deselected write and read
        host_write(1'b0, 1'b1, 3'd3, 8'hFF);
        rd_check(1'b1, 3'd3, 8'h5A, "R2 write ignored");
        idle_check("R2 read with cs_n high");

        // R4: every address of channel B, bit 0 of each value clear
        for (int a = 0; a < 8; a++)
            host_write(1'b1, 1'b0, 3'(a), 8'(8'h20 + 2 * a));
        for (int a = 0; a < 8; a++)
            rd_check(1'b0, 3'(a), 8'(8'h20 + 2 * a), "R4 address map");
        rd_check(1'b1, 3'd3, 8'h5A, "R3 A kept while B written");

        // R6: broadcast enabled through channel A's register
        host_write(1'b1, 1'b1, 3'd7, 8'h01);
        host_write(1'b1, 1'b0, 3'd1, 8'h3C);
        rd_check(1'b1, 3'd1, 8'h3C, "R6 broadcast reaches A");
        rd_check(1'b0, 3'd1, 8'h3C, "R6 broadcast reaches B");

        // R7: reads still follow chan_sel
        rd_check(1'b1, 3'd3, 8'h5A, "R7 read A in broadcast");
        rd_check(1'b0, 3'd3, 8'h26, "R7 read B in broadcast");
        idle_check("R8 idle output");

        // R9: clearing under broadcast clears both, then single-channel again
        host_write(1'b1, 1'b0, 3'd7, 8'h00);
        rd_check(1'b1, 3'd7, 8'h00, "R9 A control cleared");
        rd_check(1'b0, 3'd7, 8'h00, "R9 B control cleared");
        host_write(1'b1, 1'b1, 3'd1, 8'h77);
        rd_check(1'b1, 3'd1, 8'h77, "R9 single write A");
        rd_check(1'b0, 3'd1, 8'h3C, "R9 B untouched");

        // R6: broadcast enabled through channel B's register
        host_write(1'b1, 1'b0, 3'd7, 8'h81);
        host_write(1'b1, 1'b1, 3'd5, 8'h99);
        rd_check(1'b0, 3'd5, 8'h99, "R6 B-enabled broadcast");
        rd_check(1'b1, 3'd5, 8'h99, "R6 B-enabled broadcast A");

        // R1: reset turns broadcast off
        do_reset();
        host_write(1'b1, 1'b1, 3'd2, 8'h11);
        rd_check(1'b1, 3'd2, 8'h11, "R1 write after reset");
        rd_check(1'b0, 3'd2, 8'h00, "R1 broadcast off after reset");
        rd_check(1'b0, 3'd5, 8'h00, "R1 B cleared");

        finish_run();
    end

endmodule